// File: doc/BRIEF.md
# Reset configuration and status unit

This unit decides the 32-bit start-up configuration word of the chip each time a hard reset ends, and it keeps a small status register that records what kind of reset occurred. The word comes from one of three places, chosen by fixed priority. If the configuration-select pin is asserted, the word is the value on the external bus. Otherwise the word comes from the nonvolatile configuration register, provided that register is marked valid. An erased or invalid register makes the unit fall back to an all-zero default. The word is captured on the clock edge where the hard reset goes away, and it is held until the next hard reset ends.

The status register holds four sticky flags that software clears by writing ones. Two flags record the level of the external hard-reset and soft-reset pins. An internal reset request sets both of them, so having both set means the reset was internal. The other two flags record hard-reset and soft-reset pin pulses that last longer than a set time. That threshold is given in picoseconds and turned into a count of consecutive clock cycles. Any soft reset, whether it comes from an internal request or from a qualified external pulse, also drives the soft-reset pin output for a fixed number of cycles.

Top module: `rst_cfg_status`

## Requirements
- R1: When the hard reset ends (`hard_pin_i | int_hard_req_i` falls) with `cfg_sel_i` = 1, `cfg_word_o` becomes `bus_word_i` and `cfg_src_o` becomes 2. This holds whatever `nvm_none_i` is.
- R2: When the hard reset ends with `cfg_sel_i` = 0 and `nvm_none_i` = 0, `cfg_word_o` becomes `nvm_word_i` and `cfg_src_o` becomes 1.
- R3: When the hard reset ends with `cfg_sel_i` = 0 and `nvm_none_i` = 1 (erased memory), `cfg_word_o` becomes 0x0000_0000 and `cfg_src_o` becomes 0.
- R4: Between two hard-reset ends, `cfg_word_o` and `cfg_src_o` do not change, whatever the bus, NVM and select inputs do.
- R5: If `hard_pin_i` is held for at least LONG_CYC consecutive cycles, status bit 2 is set. LONG_CYC is threshold/period + 1, which is 3 with the defaults of 10000 ps and 20000 ps. A shorter pulse leaves bit 2 clear.
- R6: If `soft_pin_i` is held for at least LONG_CYC cycles, status bit 3 is set and `soft_drive_o` is high for DRIVE_CYC (default 4) cycles. A shorter pulse does neither.
- R7: A one-cycle `int_soft_req_i` sets status bit 3 and drives `soft_drive_o` high for DRIVE_CYC cycles.
- R8: A write sets no bit. Each of bits 3:0 is cleared by writing 1 to it and left unchanged by writing 0. Bits 7:4 are reserved and always read 0.
- R9: `int_hard_req_i` or `int_soft_req_i` sets both status bit 0 and status bit 1. `src_internal_o` is 1 exactly when bits 0 and 1 are both set.
- R10: A high `hard_pin_i` sets only bit 0 of the external-source flags. A high `soft_pin_i` sets only bit 1.
- R11: When a hard reset begins, status bits 3:2 are cleared, unless they are set again in the same cycle.
- R12: After `por_n_i` is applied, `cfg_word_o` is 0, `cfg_src_o` is 0, the status reads 0, and `soft_drive_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| hard_pin_i | input | 1 | External hard-reset pin, 1 = asserted |
| soft_pin_i | input | 1 | External soft-reset pin, 1 = asserted |
| int_hard_req_i | input | 1 | Internal hard-reset request |
| int_soft_req_i | input | 1 | Internal soft-reset request |
| cfg_sel_i | input | 1 | Configuration-select pin, 1 = take word from bus |
| bus_word_i | input | 32 | External bus value |
| nvm_word_i | input | 32 | Nonvolatile configuration word |
| nvm_none_i | input | 1 | 1 = NVM holds no valid configuration |
| reg_wr_i | input | 1 | Status write strobe |
| reg_wdata_i | input | 8 | Status write data (ones clear flags) |
| reg_rdata_o | output | 8 | Status read value |
| cfg_word_o | output | 32 | Captured configuration word |
| cfg_src_o | output | 2 | Source of captured word: 0 default, 1 NVM, 2 bus |
| src_internal_o | output | 1 | Both external flags set: internal source |
| soft_drive_o | output | 1 | Drives the soft-reset pin |

## Verification
The configuration word appears one edge after the first cycle in which the hard reset is low. The long-pulse flags appear at the edge that samples the LONG_CYC-th consecutive high pin. A write clear or a level flag takes effect on the edge after its stimulus. The soft-pin drive rises on the same edge as its flag and falls DRIVE_CYC edges later. The bench changes inputs on falling edges, so each result is sampled at the next falling edge after the rising edge that produces it, and pulse lengths are counted in rising edges.

// File: rtl/rst_cfg_pkg.sv
package rst_cfg_pkg;

  typedef enum logic [1:0] {
    SRC_DFLT = 2'd0,
    SRC_NVM  = 2'd1,
    SRC_BUS  = 2'd2
  } cfg_src_e;

  // status flag positions
  localparam int FLAG_N        = 4;
  localparam int FLAG_EXT_HARD = 0;
  localparam int FLAG_EXT_SOFT = 1;
  localparam int FLAG_LNG_HARD = 2;
  localparam int FLAG_LNG_SOFT = 3;

  // pin index in the qualifier array
  localparam int PIN_SOFT = 0;
  localparam int PIN_HARD = 1;
  localparam int PIN_N    = 2;

  // cycles a pin must be seen high to exceed min_ps strictly
  function automatic int unsigned long_cycles(int unsigned period_ps,
                                              int unsigned min_ps);
    return (min_ps / period_ps) + 1;
  endfunction

  // pin first, then validity
  function automatic cfg_src_e pick_src(logic sel, logic none);
    if (sel)        return SRC_BUS;
    else if (!none) return SRC_NVM;
    else            return SRC_DFLT;
  endfunction

endpackage

// File: rtl/rst_cfg_capture.sv
module rst_cfg_capture
  import rst_cfg_pkg::*;
#(
  parameter int          CFG_W     = 32,
  parameter logic [31:0] DFLT_WORD = 32'h0000_0000
) (
  input  logic             clk_i,
  input  logic             por_n_i,
  input  logic             hard_active_i,
  input  logic             cfg_sel_i,
  input  logic             nvm_none_i,
  input  logic [CFG_W-1:0] bus_word_i,
  input  logic [CFG_W-1:0] nvm_word_i,
  output logic [CFG_W-1:0] cfg_word_o,
  output cfg_src_e         cfg_src_o,
  output logic             onset_o
);

  logic             hard_q;
  logic             capture;
  cfg_src_e         src_next;
  logic [CFG_W-1:0] word_next;

  assign capture = hard_q & ~hard_active_i;
  assign onset_o = hard_active_i & ~hard_q;

  always_comb begin
    src_next = pick_src(cfg_sel_i, nvm_none_i);
    unique case (src_next)
      SRC_BUS: word_next = bus_word_i;
      SRC_NVM: word_next = nvm_word_i;
      default: word_next = DFLT_WORD[CFG_W-1:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      hard_q     <= 1'b0;
      cfg_word_o <= DFLT_WORD[CFG_W-1:0];
      cfg_src_o  <= SRC_DFLT;
    end else begin
      hard_q <= hard_active_i;
      if (capture) begin
        cfg_word_o <= word_next;
        cfg_src_o  <= src_next;
      end
    end
  end

  p_bus_pick_r1: assert property (@(posedge clk_i) disable iff (!por_n_i)
    capture && cfg_sel_i |=> cfg_src_o == SRC_BUS && cfg_word_o == $past(bus_word_i));

  p_nvm_pick_r2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    capture && !cfg_sel_i && !nvm_none_i |=>
      cfg_src_o == SRC_NVM && cfg_word_o == $past(nvm_word_i));

  p_dflt_pick_r3: assert property (@(posedge clk_i) disable iff (!por_n_i)
    capture && !cfg_sel_i && nvm_none_i |=>
      cfg_src_o == SRC_DFLT && cfg_word_o == DFLT_WORD[CFG_W-1:0]);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !capture |=> $stable(cfg_word_o) && $stable(cfg_src_o));

endmodule

// File: rtl/rst_pulse_qual.sv
module rst_pulse_qual #(
  parameter int LONG_CYC = 3
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic pin_i,
  output logic long_hit_o
);

  localparam int CNT_W = $clog2(LONG_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LONG_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LONG_CYC - 1);

  logic [CNT_W-1:0] run_q;

  // fires once, on the edge that samples the LONG_CYC-th high cycle
  assign long_hit_o = pin_i && (run_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)              run_q <= '0;
    else if (!pin_i)           run_q <= '0;
    else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
  end

  p_hit_single_r5: assert property (@(posedge clk_i) disable iff (!por_n_i)
    long_hit_o |=> !long_hit_o);

  p_hit_needs_run_r5: assert property (@(posedge clk_i) disable iff (!por_n_i)
    long_hit_o && (LONG_CYC > 1) |-> $past(pin_i));

endmodule

// File: rtl/rst_status_reg.sv
module rst_status_reg
  import rst_cfg_pkg::*;
#(
  parameter int STAT_W    = 8,
  parameter int DRIVE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              por_n_i,
  input  logic              onset_i,
  input  logic              ext_hard_i,
  input  logic              ext_soft_i,
  input  logic              int_hard_i,
  input  logic              int_soft_i,
  input  logic [PIN_N-1:0]  long_hit_i,
  input  logic              wr_i,
  input  logic [FLAG_N-1:0] wclr_i,
  output logic [STAT_W-1:0] rdata_o,
  output logic              src_internal_o,
  output logic              soft_drive_o
);

  localparam int DRV_W = $clog2(DRIVE_CYC + 1);

  logic [FLAG_N-1:0] flags_q;
  logic [FLAG_N-1:0] set_vec;
  logic [FLAG_N-1:0] clr_vec;
  logic [FLAG_N-1:0] onset_clr;
  logic              int_any;
  logic              soft_gen;
  logic [DRV_W-1:0]  drv_q;

  assign int_any  = int_hard_i | int_soft_i;
  assign soft_gen = int_soft_i | long_hit_i[PIN_SOFT];

  always_comb begin
    set_vec                = '0;
    set_vec[FLAG_EXT_HARD] = ext_hard_i | int_any;
    set_vec[FLAG_EXT_SOFT] = ext_soft_i | int_any;
    set_vec[FLAG_LNG_HARD] = long_hit_i[PIN_HARD];
    set_vec[FLAG_LNG_SOFT] = soft_gen;
    clr_vec                = wr_i ? wclr_i : '0;
    onset_clr              = '0;
    onset_clr[FLAG_LNG_HARD] = onset_i;
    onset_clr[FLAG_LNG_SOFT] = onset_i;
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) flags_q <= '0;
    else          flags_q <= (flags_q & ~clr_vec & ~onset_clr) | set_vec;
  end

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)        drv_q <= '0;
    else if (soft_gen)   drv_q <= DRV_W'(DRIVE_CYC);
    else if (drv_q != 0) drv_q <= drv_q - 1'b1;
  end

  assign soft_drive_o   = (drv_q != '0);
  assign src_internal_o = flags_q[FLAG_EXT_HARD] & flags_q[FLAG_EXT_SOFT];

  generate
    if (STAT_W > FLAG_N) begin : g_pad
      assign rdata_o = {{(STAT_W-FLAG_N){1'b0}}, flags_q};
    end else begin : g_nopad
      assign rdata_o = flags_q;
    end
  endgenerate

  p_gen_drive_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    soft_gen |=> soft_drive_o && rdata_o[FLAG_LNG_SOFT]);

  p_int_soft_r7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    int_soft_i |=> rdata_o[FLAG_LNG_SOFT]);

  p_w1c_keep_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
    wr_i && !wclr_i[FLAG_EXT_HARD] && rdata_o[FLAG_EXT_HARD] |=> rdata_o[FLAG_EXT_HARD]);

  p_w1c_clear_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
    wr_i && wclr_i[FLAG_LNG_HARD] && !long_hit_i[PIN_HARD] |=> !rdata_o[FLAG_LNG_HARD]);

  p_internal_both_r9: assert property (@(posedge clk_i) disable iff (!por_n_i)
    int_any |=> src_internal_o);

  p_onset_clear_r11: assert property (@(posedge clk_i) disable iff (!por_n_i)
    onset_i && !soft_gen |=> !rdata_o[FLAG_LNG_SOFT]);

endmodule

// File: rtl/rst_cfg_status.sv
module rst_cfg_status
  import rst_cfg_pkg::*;
#(
  parameter int          CFG_W       = 32,
  parameter int          STAT_W      = 8,
  parameter int          CLK_PS      = 10000,
  parameter int          MIN_PULSE_PS = 20000,
  parameter int          DRIVE_CYC   = 4,
  parameter logic [31:0] DFLT_WORD   = 32'h0000_0000
) (
  input  logic              clk_i,
  input  logic              por_n_i,
  input  logic              hard_pin_i,
  input  logic              soft_pin_i,
  input  logic              int_hard_req_i,
  input  logic              int_soft_req_i,
  input  logic              cfg_sel_i,
  input  logic [CFG_W-1:0]  bus_word_i,
  input  logic [CFG_W-1:0]  nvm_word_i,
  input  logic              nvm_none_i,
  input  logic              reg_wr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [STAT_W-1:0] reg_rdata_o,
  output logic [CFG_W-1:0]  cfg_word_o,
  output logic [1:0]        cfg_src_o,
  output logic              src_internal_o,
  output logic              soft_drive_o
);

  localparam int LONG_CYC = int'(long_cycles(CLK_PS, MIN_PULSE_PS));

  logic             hard_active;
  logic             onset;
  cfg_src_e         src_e;
  logic [PIN_N-1:0] pin_vec;
  logic [PIN_N-1:0] long_hit;

  assign hard_active = hard_pin_i | int_hard_req_i;
  assign cfg_src_o   = src_e;

  rst_cfg_capture #(
    .CFG_W     (CFG_W),
    .DFLT_WORD (DFLT_WORD)
  ) u_capture (
    .clk_i         (clk_i),
    .por_n_i       (por_n_i),
    .hard_active_i (hard_active),
    .cfg_sel_i     (cfg_sel_i),
    .nvm_none_i    (nvm_none_i),
    .bus_word_i    (bus_word_i),
    .nvm_word_i    (nvm_word_i),
    .cfg_word_o    (cfg_word_o),
    .cfg_src_o     (src_e),
    .onset_o       (onset)
  );

  always_comb begin
    pin_vec           = '0;
    pin_vec[PIN_SOFT] = soft_pin_i;
    pin_vec[PIN_HARD] = hard_pin_i;
  end

  generate
    for (genvar g = 0; g < PIN_N; g++) begin : g_qual
      rst_pulse_qual #(.LONG_CYC(LONG_CYC)) u_qual (
        .clk_i      (clk_i),
        .por_n_i    (por_n_i),
        .pin_i      (pin_vec[g]),
        .long_hit_o (long_hit[g])
      );
    end
  endgenerate

  logic unused_wdata;
  generate
    if (STAT_W > FLAG_N) begin : g_wres
      assign unused_wdata = ^reg_wdata_i[STAT_W-1:FLAG_N];
    end else begin : g_wnores
      assign unused_wdata = 1'b0;
    end
  endgenerate

  rst_status_reg #(
    .STAT_W    (STAT_W),
    .DRIVE_CYC (DRIVE_CYC)
  ) u_status (
    .clk_i          (clk_i),
    .por_n_i        (por_n_i),
    .onset_i        (onset),
    .ext_hard_i     (hard_pin_i),
    .ext_soft_i     (soft_pin_i),
    .int_hard_i     (int_hard_req_i),
    .int_soft_i     (int_soft_req_i),
    .long_hit_i     (long_hit),
    .wr_i           (reg_wr_i),
    .wclr_i         (reg_wdata_i[FLAG_N-1:0]),
    .rdata_o        (reg_rdata_o),
    .src_internal_o (src_internal_o),
    .soft_drive_o   (soft_drive_o)
  );

  p_reserved_zero_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
    reg_rdata_o[STAT_W-1:FLAG_N] == '0);

  p_ext_hard_only_r10: assert property (@(posedge clk_i) disable iff (!por_n_i)
    hard_pin_i |=> reg_rdata_o[FLAG_EXT_HARD]);

endmodule

// File: tb/test_rst_cfg_status.sv
module test_rst_cfg_status;

  localparam int CLK_PERIOD = 10;
  localparam int LONG = 3;
  localparam int DRV  = 4;

  logic        clk = 1'b0;
  logic        por_n, hard_pin, soft_pin, int_hard, int_soft, cfg_sel, nvm_none, reg_wr;
  logic [31:0] bus_word, nvm_word;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [31:0] cfg_word;
  logic [1:0]  cfg_src;
  logic        src_int, soft_drive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_cfg_status i_rst_cfg_status (
    .clk_i(clk), .por_n_i(por_n), .hard_pin_i(hard_pin), .soft_pin_i(soft_pin),
    .int_hard_req_i(int_hard), .int_soft_req_i(int_soft), .cfg_sel_i(cfg_sel),
    .bus_word_i(bus_word), .nvm_word_i(nvm_word), .nvm_none_i(nvm_none),
    .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .cfg_word_o(cfg_word), .cfg_src_o(cfg_src), .src_internal_o(src_int),
    .soft_drive_o(soft_drive)
  );

  function automatic logic [31:0] exp_word(logic s, logic n, logic [31:0] b, logic [31:0] v);
    if (s) return b;
    return n ? 32'h0 : v;
  endfunction

  function automatic logic [1:0] exp_src(logic s, logic n);
    return s ? 2'd2 : (n ? 2'd0 : 2'd1);
  endfunction

  function automatic logic exp_long(int len);
    return len >= LONG;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_stat(logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step(1);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic hard_pulse(int len);
    hard_pin = 1'b1;
    step(len);
    hard_pin = 1'b0;
    step(1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] b, v;
    logic s, n;
    int len;
    por_n = 1'b0; hard_pin = 0; soft_pin = 0; int_hard = 0; int_soft = 0;
    cfg_sel = 0; nvm_none = 0; reg_wr = 0; reg_wdata = 0;
    bus_word = 32'hA5A5_0001; nvm_word = 32'h1234_5678;
    void'($urandom(32'd2024));
    step(3);
    por_n = 1'b1;
    step(1);
    // R12 reset state
    chk("R12 cfg", cfg_word, 32'h0);
    chk("R12 src", {30'd0, cfg_src}, 32'd0);
    chk("R12 status", {24'd0, reg_rdata}, 32'd0);
    chk("R12 drive", {31'd0, soft_drive}, 32'd0);

    // directed source corners: R1 bus beats valid NVM, R3 erased falls back
    cfg_sel = 1; nvm_none = 0; bus_word = 32'hDEAD_BEEF; nvm_word = 32'h0BAD_F00D;
    hard_pulse(2);
    chk("R1 bus word", cfg_word, 32'hDEAD_BEEF);
    chk("R1 bus src", {30'd0, cfg_src}, 32'd2);
    chk("R5 short hard no flag", {31'd0, reg_rdata[2]}, 32'd0);
    cfg_sel = 0; nvm_none = 1;
    hard_pulse(3);
    chk("R3 default word", cfg_word, 32'h0);
    chk("R3 default src", {30'd0, cfg_src}, 32'd0);
    chk("R5 long hard flag", {31'd0, reg_rdata[2]}, 32'd1);
    cfg_sel = 0; nvm_none = 0;
    hard_pulse(1);
    chk("R2 nvm word", cfg_word, 32'h0BAD_F00D);
    chk("R11 onset cleared long hard", {31'd0, reg_rdata[2]}, 32'd0);

    // random capture and long-pulse checks: R1 R2 R3 R5
    for (int i = 0; i < 40; i++) begin
      b = $urandom; v = $urandom; s = 1'($urandom % 2); n = 1'($urandom % 2);
      len = 1 + int'($urandom % 5);
      bus_word = b; nvm_word = v; cfg_sel = s; nvm_none = n;
      hard_pulse(len);
      chk(s ? "R1 rnd word" : (n ? "R3 rnd word" : "R2 rnd word"), cfg_word, exp_word(s, n, b, v));
      chk("R1 R2 R3 rnd src", {30'd0, cfg_src}, {30'd0, exp_src(s, n)});
      chk("R5 rnd long flag", {31'd0, reg_rdata[2]}, {31'd0, exp_long(len)});
    end

    // R4 hold: inputs move, no hard reset end
    b = cfg_word;
    for (int i = 0; i < 6; i++) begin
      bus_word = $urandom; nvm_word = $urandom;
      cfg_sel = 1'($urandom % 2); nvm_none = 1'($urandom % 2);
      step(1);
    end
    chk("R4 word held", cfg_word, b);

    // R10 external level flags
    wr_stat(8'hFF);
    chk("R8 clear all", {24'd0, reg_rdata}, 32'd0);
    soft_pin = 1; step(1); soft_pin = 0;
    chk("R10 soft pin only bit1", {24'd0, reg_rdata}, 32'h02);
    chk("R6 short soft no drive", {31'd0, soft_drive}, 32'd0);
    step(1);
    hard_pulse(1);
    chk("R10 hard pin sets bit0", {24'd0, reg_rdata}, 32'h03);
    chk("R9 external both", {31'd0, src_int}, 32'd1);

    // R8 write one clears, zero keeps, reserved read zero
    wr_stat(8'h02);
    chk("R8 w1c bit1", {24'd0, reg_rdata}, 32'h01);
    chk("R9 not internal", {31'd0, src_int}, 32'd0);
    wr_stat(8'h00);
    chk("R8 w0 keeps", {24'd0, reg_rdata}, 32'h01);
    wr_stat(8'hF0);
    chk("R8 reserved write", {24'd0, reg_rdata}, 32'h01);
    wr_stat(8'h0F);
    chk("R8 clear rest", {24'd0, reg_rdata}, 32'h00);

    // R6 long soft pulse and drive length
    soft_pin = 1; step(LONG);
    chk("R6 long soft flag", {31'd0, reg_rdata[3]}, 32'd1);
    chk("R6 drive start", {31'd0, soft_drive}, 32'd1);
    soft_pin = 0;
    step(DRV - 1);
    chk("R6 drive last", {31'd0, soft_drive}, 32'd1);
    step(1);
    chk("R6 drive end", {31'd0, soft_drive}, 32'd0);

    // R7 R9 internal soft request
    wr_stat(8'h0F);
    int_soft = 1; step(1); int_soft = 0;
    chk("R7 int soft flags", {24'd0, reg_rdata}, 32'h0B);
    chk("R7 int soft drive", {31'd0, soft_drive}, 32'd1);
    chk("R9 int soft internal", {31'd0, src_int}, 32'd1);
    step(DRV);
    chk("R7 drive done", {31'd0, soft_drive}, 32'd0);

    // R11 hard onset clears bit3
    hard_pin = 1; step(1);
    chk("R11 onset clears bit3", {30'd0, reg_rdata[3:2]}, 32'd0);
    hard_pin = 0; step(1);

    // R9 internal hard request
    wr_stat(8'h0F);
    int_hard = 1; step(1); int_hard = 0;
    chk("R9 int hard flags", {24'd0, reg_rdata}, 32'h03);
    chk("R9 int hard internal", {31'd0, src_int}, 32'd1);
    step(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule